// File: doc/BRIEF.md
# Soft-Stepping Stereo Volume Controller

This block attenuates a stereo stream of 20-bit signed samples, with a separate level for each channel. A host sets a target level for each channel. The block does not jump to a new target. It moves the applied level one 0.5 dB code at a time, at a fixed interval, until the level matches the target. The interval is counted from a one-microsecond tick. A slow-rate bit doubles the interval. A host can poll the done output to learn when every channel has reached its target, for example before it reconfigures the audio path.

The same ramp also serves a small sequencer. When the power request rises, the power enable goes high and the output ramps up from mute. When the power request falls, the output ramps to mute before the power enable drops. When a de-emphasis or bass-boost request changes while the block is powered, both channels ramp to mute first. The new effect setting is then applied, and the channels ramp back to their targets. The effect filters are outside this block. It only presents the applied settings.

Top module: `svol_ramp_top`

## Requirements
- R1: A target is a 7-bit code. Code 0 is 0 dB, and each increment adds 0.5 dB of attenuation, down to −63.5 dB at code 127. The applied level also has a mute code, 128, at which the channel output is exactly 0.
- R2: Coefficient c(0)=32768 and c(k+1)=floor((c(k)·61870+32768)/65536). An input sample x at applied level k<128 gives floor((x·c(k)+16384)/32768), saturated to the 20-bit signed range. Each output appears one cycle after its input, with out_valid following in_valid.
- R3: The two channels have independent targets. When a channel's mute bit is 1, the goal of that channel is the mute code and it ramps there. The other channel is not affected.
- R4: While any channel differs from its goal, the tick_us pulses are counted. On every 20th pulse (every 40th when rate_slow=1), each channel that is off its goal moves one code toward it. The count is cleared whenever both channels are at their goals, so the first step comes exactly 20 or 40 pulses after a goal departs.
- R5: done is 1 only when both applied levels equal their goals and no power-down or effect sequence is running. It is 1 after reset.
- R6: pwr_en rises one cycle after pwr_req rises in the off state. The output starts at mute and ramps up to the targets.
- R7: When pwr_req falls, both channels ramp to mute. pwr_en falls one cycle after both channels reach mute.
- R8: While powered, a change on fx_req (bit 0 de-emphasis, bit 1 bass boost) makes both channels ramp to mute. fx_out then takes the new value one cycle after both channels are muted, and the channels ramp back to their goals. done stays 0 until they arrive.
- R9: While powered off, fx_out takes fx_req one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_req | input | 1 | Power request from the host |
| rate_slow | input | 1 | 1 selects the 40-tick step interval |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| tgt_l | input | 7 | Left target level code |
| tgt_r | input | 7 | Right target level code |
| mute_l | input | 1 | Left mute request |
| mute_r | input | 1 | Right mute request |
| fx_req | input | 2 | Requested effects: bit 0 de-emphasis, bit 1 bass boost |
| in_valid | input | 1 | Input sample strobe |
| in_l | input | 20 | Left input sample, signed |
| in_r | input | 20 | Right input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_l | output | 20 | Left scaled sample, signed |
| out_r | output | 20 | Right scaled sample, signed |
| fx_out | output | 2 | Applied effect settings |
| pwr_en | output | 1 | Power enable for the converters |
| done | output | 1 | Applied levels equal goals |

## Verification
A scaled sample appears one cycle after its input strobe. The bench's monitor therefore pops the expected value at the falling edge after the one where the sample was driven. A level step takes effect at the clock edge that sees the counted tick, so done and the output samples are checked at the falling edge that ends that tick pulse. The bench counts pulses up to one short of each due step and checks that nothing has moved yet, then gives the last pulse and checks again. fx_out and pwr_en change one further cycle after mute is reached. The bench waits exactly one extra falling edge before it checks them.

// File: rtl/svol_pkg.sv
package svol_pkg;

  localparam int COEF_W     = 16;
  localparam int COEF_FRAC  = 15;
  localparam int COEF_UNITY = 32768;
  localparam int STEP_MUL   = 61870;

  typedef enum logic [1:0] {
    SQ_OFF  = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FXDN = 2'd2,
    SQ_PWDN = 2'd3
  } sq_state_t;

  // linear gain for a level code: unity scaled by the 0.5 dB ratio idx times
  function automatic logic [COEF_W-1:0] coef_of(input int idx);
    longint acc;
    acc = longint'(COEF_UNITY);
    for (int k = 0; k < idx; k++) begin
      acc = (acc * longint'(STEP_MUL) + 64'sd32768) >>> 16;
    end
    return acc[COEF_W-1:0];
  endfunction

endpackage

// File: rtl/svol_step_gen.sv
module svol_step_gen #(
  parameter int FAST_N = 20,
  parameter int SLOW_N = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic slow,
  input  logic busy,
  output logic step_go
);
  localparam int CNT_W = $clog2(SLOW_N + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim     = slow ? CNT_W'(SLOW_N - 1) : CNT_W'(FAST_N - 1);
  assign step_go = busy && tick && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!busy || step_go) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/svol_chan_ramp.sv
module svol_chan_ramp #(
  parameter int LVL_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_go,
  input  logic [LVL_W:0] goal,
  output logic [LVL_W:0] lvl,
  output logic           at_goal
);
  localparam logic [LVL_W:0] MUTE = (LVL_W + 1)'(2 ** LVL_W);

  assign at_goal = (lvl == goal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= MUTE;
    end else if (step_go && !at_goal) begin
      if (lvl < goal) lvl <= lvl + 1'b1;
      else            lvl <= lvl - 1'b1;
    end
  end
endmodule

// File: rtl/svol_seq.sv
module svol_seq
  import svol_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_req,
  input  logic [1:0] fx_req,
  input  logic       all_muted,
  output sq_state_t  st,
  output logic [1:0] fx_out,
  output logic       pwr_en,
  output logic       hold_mute,
  output logic       fx_hold
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SQ_OFF;
      fx_out <= 2'b00;
    end else begin
      unique case (st)
        SQ_OFF: begin
          fx_out <= fx_req;
          if (pwr_req) st <= SQ_RUN;
        end
        SQ_RUN: begin
          if (!pwr_req)             st <= SQ_PWDN;
          else if (fx_req != fx_out) st <= SQ_FXDN;
        end
        SQ_FXDN: begin
          if (!pwr_req) begin
            st <= SQ_PWDN;
          end else if (all_muted) begin
            fx_out <= fx_req;
            st     <= SQ_RUN;
          end
        end
        SQ_PWDN: begin
          if (all_muted) st <= SQ_OFF;
        end
        default: st <= SQ_OFF;
      endcase
    end
  end

  assign pwr_en    = (st != SQ_OFF);
  assign hold_mute = (st != SQ_RUN);
  assign fx_hold   = (st == SQ_FXDN) || (st == SQ_PWDN);
endmodule

// File: rtl/svol_gain.sv
module svol_gain
  import svol_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int LVL_W  = 7,
  parameter int NCH    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [NCH-1:0][DATA_W-1:0]    in_smp,
  input  logic [NCH-1:0][LVL_W:0]       lvl,
  output logic                          out_valid,
  output logic [NCH-1:0][DATA_W-1:0]    out_smp
);
  localparam int NLVL = 2 ** LVL_W;
  localparam int PW   = DATA_W + COEF_W + 1;

  localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (COEF_FRAC - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -PW'(64'sd1 <<< (DATA_W - 1));

  function automatic logic [DATA_W-1:0] scale_sat(input logic [DATA_W-1:0] x,
                                                   input logic [COEF_W-1:0] c);
    logic signed [PW-1:0] p;
    logic signed [PW-1:0] r;
    p = PW'($signed(x)) * $signed({1'b0, c});
    r = (p + HALF) >>> COEF_FRAC;
    if (r > MAXV)      r = MAXV;
    else if (r < MINV) r = MINV;
    return r[DATA_W-1:0];
  endfunction

  logic [COEF_W-1:0] coef_tab [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_coef
    assign coef_tab[g] = coef_of(g);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic              muted;
    logic [COEF_W-1:0] coef;
    assign muted = lvl[ch][LVL_W];
    assign coef  = coef_tab[lvl[ch][LVL_W-1:0]];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_smp[ch] <= '0;
      end else if (in_valid) begin
        out_smp[ch] <= muted ? '0 : scale_sat(in_smp[ch], coef);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end
endmodule

// File: rtl/svol_ramp_top.sv
module svol_ramp_top
  import svol_pkg::*;
#(
  parameter int DATA_W     = 20,
  parameter int LVL_W      = 7,
  parameter int FAST_TICKS = 20,
  parameter int SLOW_TICKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_req,
  input  logic              rate_slow,
  input  logic              tick_us,
  input  logic [LVL_W-1:0]  tgt_l,
  input  logic [LVL_W-1:0]  tgt_r,
  input  logic              mute_l,
  input  logic              mute_r,
  input  logic [1:0]        fx_req,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_l,
  input  logic [DATA_W-1:0] in_r,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_l,
  output logic [DATA_W-1:0] out_r,
  output logic [1:0]        fx_out,
  output logic              pwr_en,
  output logic              done
);
  localparam int NCH = 2;
  localparam logic [LVL_W:0] MUTE = (LVL_W + 1)'(2 ** LVL_W);

  logic [NCH-1:0][LVL_W:0]    goal;
  logic [NCH-1:0][LVL_W:0]    lvl_app;
  logic [NCH-1:0]             at_goal;
  logic [NCH-1:0][DATA_W-1:0] smp_in;
  logic [NCH-1:0][DATA_W-1:0] smp_out;
  logic [NCH-1:0]             mute_req;
  logic [NCH-1:0][LVL_W-1:0]  tgt;

  sq_state_t st;
  logic      hold_mute;
  logic      fx_hold;
  logic      step_go;
  logic      busy;
  logic      all_muted;
  logic [LVL_W:0] lvl_l;
  logic [LVL_W:0] lvl_r;

  assign tgt      = {tgt_r, tgt_l};
  assign mute_req = {mute_r, mute_l};
  assign smp_in   = {in_r, in_l};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    assign goal[ch] = (hold_mute || mute_req[ch]) ? MUTE : {1'b0, tgt[ch]};

    svol_chan_ramp #(.LVL_W(LVL_W)) ramp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_go (step_go),
      .goal    (goal[ch]),
      .lvl     (lvl_app[ch]),
      .at_goal (at_goal[ch])
    );
  end

  assign busy      = !(&at_goal);
  assign lvl_l     = lvl_app[0];
  assign lvl_r     = lvl_app[1];
  assign all_muted = (lvl_l == MUTE) && (lvl_r == MUTE);

  svol_step_gen #(.FAST_N(FAST_TICKS), .SLOW_N(SLOW_TICKS)) step_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_us),
    .slow    (rate_slow),
    .busy    (busy),
    .step_go (step_go)
  );

  svol_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_req   (pwr_req),
    .fx_req    (fx_req),
    .all_muted (all_muted),
    .st        (st),
    .fx_out    (fx_out),
    .pwr_en    (pwr_en),
    .hold_mute (hold_mute),
    .fx_hold   (fx_hold)
  );

  svol_gain #(.DATA_W(DATA_W), .LVL_W(LVL_W), .NCH(NCH)) gain_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_smp    (smp_in),
    .lvl       (lvl_app),
    .out_valid (out_valid),
    .out_smp   (smp_out)
  );

  assign out_l = smp_out[0];
  assign out_r = smp_out[1];
  assign done  = ((st == SQ_RUN) || (st == SQ_OFF)) && !busy;
endmodule

// File: rtl/svol_ramp_chk.sv
module svol_ramp_chk #(
  parameter int DATA_W = 20,
  parameter int LVL_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LVL_W:0]    lvl_l,
  input logic [LVL_W:0]    lvl_r,
  input logic              step_go,
  input logic              pwr_en,
  input logic [1:0]        fx_out,
  input logic              fx_hold,
  input logic              done,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_l,
  input logic [DATA_W-1:0] out_r
);
  localparam logic [LVL_W:0] MUTE = (LVL_W + 1)'(2 ** LVL_W);

  assert_step_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_l != $past(lvl_l)) |-> ((lvl_l == $past(lvl_l) + 1'b1) || (lvl_l == $past(lvl_l) - 1'b1)));

  assert_step_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step_go) |-> ($stable(lvl_l) && $stable(lvl_r)));

  assert_mute_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(lvl_l) == MUTE && $past(lvl_r) == MUTE) |-> (out_l == '0 && out_r == '0));

  assert_pwr_up_muted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (lvl_l == MUTE && lvl_r == MUTE));

  assert_pwr_down_muted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(lvl_l == MUTE && lvl_r == MUTE));

  assert_fx_swap_muted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && $past(pwr_en) && fx_out != $past(fx_out)) |-> $past(lvl_l == MUTE && lvl_r == MUTE));

  assert_done_low_in_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fx_hold |-> !done);
endmodule

bind svol_ramp_top svol_ramp_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .lvl_l     (lvl_l),
  .lvl_r     (lvl_r),
  .step_go   (step_go),
  .pwr_en    (pwr_en),
  .fx_out    (fx_out),
  .fx_hold   (fx_hold),
  .done      (done),
  .out_valid (out_valid),
  .out_l     (out_l),
  .out_r     (out_r)
);

// File: tb/svol_ramp_top_tb_top.sv
module svol_ramp_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_req = 1'b0;
  logic rate_slow = 1'b0;
  logic tick_us = 1'b0;
  logic [6:0] tgt_l = '0;
  logic [6:0] tgt_r = '0;
  logic mute_l = 1'b0;
  logic mute_r = 1'b0;
  logic [1:0] fx_req = 2'b00;
  logic in_valid = 1'b0;
  logic signed [19:0] in_l = '0;
  logic signed [19:0] in_r = '0;
  logic out_valid;
  logic signed [19:0] out_l;
  logic signed [19:0] out_r;
  logic [1:0] fx_out;
  logic pwr_en;
  logic done;

  int total = 0;
  int bad = 0;

  typedef struct { longint l; longint r; string tag; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  svol_ramp_top dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .rate_slow(rate_slow),
    .tick_us(tick_us), .tgt_l(tgt_l), .tgt_r(tgt_r), .mute_l(mute_l),
    .mute_r(mute_r), .fx_req(fx_req), .in_valid(in_valid), .in_l(in_l),
    .in_r(in_r), .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
    .fx_out(fx_out), .pwr_en(pwr_en), .done(done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint gain_of(input int k);
    longint c = 32768;
    for (int i = 0; i < k; i++) c = (c * 61870 + 32768) / 65536;
    return c;
  endfunction

  function automatic longint model(input longint x, input int lvl);
    longint v;
    if (lvl >= 128) return 0;
    v = (x * gain_of(lvl) + 16384) >>> 15;
    if (v > 524287) v = 524287;
    if (v < -524288) v = -524288;
    return v;
  endfunction

  task automatic send(input string tag, input longint xl, input longint xr,
                      input int ll, input int lr);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_l = 20'(xl);
    in_r = 20'(xr);
    e.l = model(xl, ll);
    e.r = model(xr, lr);
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_us = 1'b1;
      @(negedge clk) tick_us = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected output", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " left"}, longint'(out_l), e.l);
        chk({e.tag, " right"}, longint'(out_r), e.r);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset pwr_en", pwr_en, 0);
    chk("R5 reset done", done, 1);
    chk("R8 reset fx_out", fx_out, 0);
    chk("R2 reset out_valid", out_valid, 0);
    send("R1 off muted", 300000, -300000, 128, 128);

    // R6 power-up ramp from mute
    pwr_req = 1'b1; tgt_l = 7'd10; tgt_r = 7'd10;
    @(negedge clk);
    chk("R6 pwr_en up", pwr_en, 1);
    chk("R5 done low on ramp", done, 0);
    ticks(19);
    send("R4 before first step", 100000, 100000, 128, 128);
    ticks(1);
    send("R4 first step", 100000, 100000, 127, 127);
    ticks(117 * 20 - 1);
    chk("R5 done before last step", done, 0);
    ticks(1);
    chk("R5 done at target", done, 1);
    send("R2 pos max", 524287, -524288, 10, 10);
    send("R2 zero and one", 0, 1, 10, 10);
    send("R2 minus one", -1, 12345, 10, 10);

    // R3 independent targets
    tgt_l = 7'd0; tgt_r = 7'd127;
    ticks(117 * 20);
    chk("R3 done both", done, 1);
    send("R1 unity and floor", 524287, 524287, 0, 127);
    send("R1 unity neg", -77777, -524288, 0, 127);

    // R3 mute one channel
    mute_r = 1'b1;
    ticks(19);
    chk("R3 mute not yet", done, 0);
    ticks(1);
    chk("R3 mute reached", done, 1);
    send("R3 right muted left kept", 4321, 4321, 0, 128);

    // R4 slow rate
    rate_slow = 1'b1; tgt_l = 7'd2;
    ticks(79);
    chk("R4 slow not yet", done, 0);
    send("R4 slow one step", 200000, 5, 1, 128);
    ticks(1);
    chk("R4 slow reached", done, 1);
    send("R4 slow level", 200000, 5, 2, 128);
    rate_slow = 1'b0;

    // R8 effect change sequence
    fx_req = 2'b01;
    @(negedge clk);
    chk("R8 done low", done, 0);
    chk("R8 fx held", fx_out, 0);
    ticks(126 * 20 - 1);
    chk("R8 fx held before mute", fx_out, 0);
    ticks(1);
    chk("R8 fx held on mute edge", fx_out, 0);
    @(negedge clk);
    chk("R8 fx applied", fx_out, 1);
    chk("R8 done low after apply", done, 0);
    ticks(126 * 20 - 1);
    chk("R8 done low before return", done, 0);
    ticks(1);
    chk("R8 done on return", done, 1);
    send("R8 restored level", -250000, 9, 2, 128);

    // R7 power-down
    pwr_req = 1'b0;
    @(negedge clk);
    chk("R7 pwr_en held", pwr_en, 1);
    chk("R5 done low in power-down", done, 0);
    ticks(126 * 20);
    chk("R7 pwr_en on mute edge", pwr_en, 1);
    @(negedge clk);
    chk("R7 pwr_en dropped", pwr_en, 0);
    chk("R5 done when off", done, 1);
    send("R7 off output zero", 123456, -123456, 128, 128);

    // R9 effect follows while off
    fx_req = 2'b10;
    @(negedge clk);
    chk("R9 fx follows when off", fx_out, 2);

    // R6 second power-up from mute
    mute_r = 1'b0; tgt_r = 7'd0; tgt_l = 7'd0;
    pwr_req = 1'b1;
    @(negedge clk);
    chk("R6 pwr_en again", pwr_en, 1);
    chk("R8 no fx sequence on power-up", fx_out, 2);
    ticks(20);
    send("R6 ramp from mute", 65536, -65536, 127, 127);

    repeat (4) @(negedge clk);
    chk("R2 all outputs seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule